// File: doc/BRIEF.md
# Cascadable Interrupt Controller Bank

This block is one bank of a banked interrupt controller. It watches 32 request lines, latches or follows each one according to a per-line trigger setting, and drops lines that the mask register blocks. It then raises a normal interrupt output and a fast interrupt output to the processor. Each line has its own configuration word. That word chooses the output the line is routed to, the trigger type and a 5-bit priority. Two independent arbiters, one per output, pick a winner among the unmasked pending lines and hold it until software acknowledges it.

Several banks are used together as a tree. A global interrupt number splits into a bank number (the number shifted right by 5) and a line index (the low 5 bits). The bank built with `IS_PRIMARY = 1` is the only one whose lines may be routed to the fast output. A secondary bank's normal output is wired into one request line of the primary bank. Software first acknowledges the secondary bank and then the primary. Software reaches every register through a simple synchronous read/write port. Read data appears one clock after `rd_en`.

Top module: `irq_bank`

## Requirements
- R1: Line n has a configuration word at byte address 0x80 + 4*n. In that word, bit 0 routes the line to the fast output (1) or the normal output (0), bit 1 selects level (1) or rising-edge (0) triggering, and bits 6:2 hold the priority. The word reads back as written, and its reset value is 0.
- R2: The mask register is at 0x04. A 1 in bit n blocks line n from both arbiters, and a 0 lets it through. The register resets to all ones.
- R3: The global mask is bit 0 at 0x14 and resets to 1. While it is 1, both `irq_o` and `fiq_o` are low. Clearing it lets a held request out on the next clock.
- R4: In a bank built with `IS_PRIMARY = 0`, configuration bit 0 is stored and read back as 0, so every line goes to the normal output and `fiq_o` stays low.
- R5: On an edge line, a rising input sets the line's status bit, which stays set after the input drops until it is acknowledged or cleared. The output rises two clocks after the input edge.
- R6: On a level line, the status bit (readable at 0x00) follows the input one clock later, whether the line is masked or not.
- R7: Each arbiter considers only the unmasked pending lines routed to its own output. The lowest priority value wins, and on a tie the lowest line index wins.
- R8: The normal source register (0x08) and the fast source register (0x0C) read bit 31 = request held and bits 4:0 = winning line. The winner stays frozen while held, even if a better request arrives.
- R9: Writing the control register (0x10) with bit 0 set acknowledges the normal output, and with bit 1 set acknowledges the fast output. Each acknowledge affects only its own output, and writing 0x3 acknowledges both.
- R10: After an acknowledge, the output is low on the next clock and arbitration restarts one clock later. The acknowledged edge line's status bit is cleared, so a second pending line is presented next.
- R11: A write to the status register ANDs the written value into the status bits, so writing 0 clears every latched bit.
- R12: A secondary bank's `irq_o`, fed into a level line of the primary bank, raises the primary's `irq_o`. Acknowledging the secondary alone does not drop the primary output, and the primary's own acknowledge drops it.
- R13: After reset, both outputs are low, the status register reads 0 and both source registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_LINES | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid one clock after rd_en |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The arbitration is driven with level request patterns: single lines at both ends of the index range, pairs where priority decides, and pairs of equal priority where only the index decides. These patterns separate a wrong priority compare from a wrong tie rule. Edge lines are pulsed for a single cycle to show latching, and two pulsed lines of equal priority show that an acknowledge clears only the winner and that the second line follows after a one-clock gap. A late, better request during a hold separates a frozen winner from a live one. Mixed normal and fast traffic, partial status writes and a two-bank chain show that the acknowledges are independent, that status writes clear only the zero bits, and that both banks must be acknowledged.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  // register byte offsets
  localparam int unsigned OFS_STATUS  = 'h00;
  localparam int unsigned OFS_MASK    = 'h04;
  localparam int unsigned OFS_SRC_IRQ = 'h08;
  localparam int unsigned OFS_SRC_FIQ = 'h0C;
  localparam int unsigned OFS_CTRL    = 'h10;
  localparam int unsigned OFS_GMASK   = 'h14;

  // control and configuration bit positions
  localparam int unsigned CTRL_ACK_IRQ = 0;
  localparam int unsigned CTRL_ACK_FIQ = 1;
  localparam int unsigned CFG_FIQ      = 0;
  localparam int unsigned CFG_LVL      = 1;
  localparam int unsigned CFG_PRIO_LSB = 2;

  typedef enum logic {ARB_IDLE = 1'b0, ARB_HOLD = 1'b1} arb_state_t;
endpackage

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
  import irq_bank_pkg::*;
#(
  parameter int unsigned N_LINES    = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PRIO_W     = 5,
  parameter int unsigned IDX_W      = 5,
  parameter bit          IS_PRIMARY = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [N_LINES-1:0]             status,
  input  logic                           src_irq_vld,
  input  logic [IDX_W-1:0]               src_irq_idx,
  input  logic                           src_fiq_vld,
  input  logic [IDX_W-1:0]               src_fiq_idx,
  output logic [N_LINES-1:0]             mask,
  output logic                           gmask,
  output logic [N_LINES-1:0]             cfg_fiq,
  output logic [N_LINES-1:0]             cfg_lvl,
  output logic [N_LINES-1:0][PRIO_W-1:0] cfg_prio,
  output logic                           ack_irq,
  output logic                           ack_fiq,
  output logic                           stat_wr,
  output logic [DATA_W-1:0]              rdata
);
  // configuration words occupy the upper half of the address space
  logic             cfg_sel;
  logic [IDX_W-1:0] cfg_idx;
  logic             ctrl_wr;
  logic [DATA_W-1:0] rd_next;

  assign cfg_sel = addr[ADDR_W-1] && (addr[1:0] == 2'b00);
  assign cfg_idx = addr[IDX_W+1:2];
  assign ctrl_wr = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign ack_irq = ctrl_wr && wdata[CTRL_ACK_IRQ];
  assign ack_fiq = ctrl_wr && wdata[CTRL_ACK_FIQ];
  assign stat_wr = wr_en && (addr == ADDR_W'(OFS_STATUS));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '1;
      gmask <= 1'b1;
    end else if (wr_en) begin
      if (addr == ADDR_W'(OFS_MASK))  mask  <= wdata[N_LINES-1:0];
      if (addr == ADDR_W'(OFS_GMASK)) gmask <= wdata[0];
    end
  end

  // per-line configuration; read in parallel by the arbiters, so kept in flops
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_fiq  <= '0;
      cfg_lvl  <= '0;
      cfg_prio <= '0;
    end else if (wr_en && cfg_sel) begin
      for (int n = 0; n < N_LINES; n++) begin
        if (cfg_idx == IDX_W'(n)) begin
          cfg_fiq[n]  <= IS_PRIMARY & wdata[CFG_FIQ];
          cfg_lvl[n]  <= wdata[CFG_LVL];
          cfg_prio[n] <= wdata[CFG_PRIO_LSB +: PRIO_W];
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (cfg_sel) begin
      rd_next[CFG_FIQ]                 = cfg_fiq[cfg_idx];
      rd_next[CFG_LVL]                 = cfg_lvl[cfg_idx];
      rd_next[CFG_PRIO_LSB +: PRIO_W]  = cfg_prio[cfg_idx];
    end else begin
      case (addr)
        ADDR_W'(OFS_STATUS):  rd_next[N_LINES-1:0] = status;
        ADDR_W'(OFS_MASK):    rd_next[N_LINES-1:0] = mask;
        ADDR_W'(OFS_SRC_IRQ): begin
          rd_next[DATA_W-1]  = src_irq_vld;
          rd_next[IDX_W-1:0] = src_irq_idx;
        end
        ADDR_W'(OFS_SRC_FIQ): begin
          rd_next[DATA_W-1]  = src_fiq_vld;
          rd_next[IDX_W-1:0] = src_fiq_idx;
        end
        ADDR_W'(OFS_GMASK):   rd_next[0] = gmask;
        default:              rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/irq_bank_status.sv
module irq_bank_status #(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req,
  input  logic [N_LINES-1:0] cfg_lvl,
  input  logic [N_LINES-1:0] clr,
  input  logic               stat_wr,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] status
);
  logic [N_LINES-1:0] req_q;
  logic [N_LINES-1:0] keep;
  logic [N_LINES-1:0] edge_next;
  logic [N_LINES-1:0] status_next;

  always_comb begin
    keep        = stat_wr ? wdata : '1;
    edge_next   = (status & ~clr & keep) | (req & ~req_q);
    status_next = (cfg_lvl & req) | (~cfg_lvl & edge_next);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      status <= '0;
    end else begin
      req_q  <= req;
      status <= status_next;
    end
  end

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((status & $past(status & ~cfg_lvl & ~clr)) == $past(status & ~cfg_lvl & ~clr))); // R5
endmodule

// File: rtl/irq_bank_arb.sv
module irq_bank_arb
  import irq_bank_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned PRIO_W  = 5,
  parameter int unsigned IDX_W   = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_LINES-1:0]             elig,
  input  logic [N_LINES-1:0][PRIO_W-1:0] prio,
  input  logic                           ack,
  output logic                           hold,
  output logic [IDX_W-1:0]               win_idx,
  output logic [N_LINES-1:0]             clr
);
  arb_state_t        state;
  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;

  // ascending scan with strict compare: lowest value, then lowest index
  always_comb begin
    found  = 1'b0;
    best_p = '1;
    best_i = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (elig[i] && (!found || (prio[i] < best_p))) begin
        found  = 1'b1;
        best_p = prio[i];
        best_i = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ARB_IDLE;
      win_idx <= '0;
    end else begin
      case (state)
        ARB_IDLE: if (found) begin
          state   <= ARB_HOLD;
          win_idx <= best_i;
        end
        ARB_HOLD: if (ack) state <= ARB_IDLE;
        default:  state <= ARB_IDLE;
      endcase
    end
  end

  assign hold = (state == ARB_HOLD);

  for (genvar i = 0; i < N_LINES; i++) begin : g_clr
    assign clr[i] = hold && ack && (win_idx == IDX_W'(i));
  end

  AST_ACK_GAP: assert property (@(posedge clk) disable iff (rst)
    (hold && ack) |=> !hold); // R10
  AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (hold && !ack) |=> (hold && $stable(win_idx))); // R8
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(|elig)); // R7
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned N_LINES    = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PRIO_W     = 5,
  parameter bit          IS_PRIMARY = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int unsigned IDX_W = $clog2(N_LINES);
  localparam int unsigned N_OUT = 2; // 0: normal, 1: fast

  logic [N_LINES-1:0]             mask, status, cfg_fiq, cfg_lvl;
  logic [N_LINES-1:0][PRIO_W-1:0] cfg_prio;
  logic                           gmask, stat_wr;
  logic [N_OUT-1:0]               ack, hold;
  logic [N_OUT-1:0][IDX_W-1:0]    win;
  logic [N_OUT-1:0][N_LINES-1:0]  elig, clr;

  irq_bank_regs #(
    .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PRIO_W(PRIO_W), .IDX_W(IDX_W), .IS_PRIMARY(IS_PRIMARY)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status(status),
    .src_irq_vld(hold[0]), .src_irq_idx(win[0]),
    .src_fiq_vld(hold[1]), .src_fiq_idx(win[1]),
    .mask(mask), .gmask(gmask), .cfg_fiq(cfg_fiq), .cfg_lvl(cfg_lvl),
    .cfg_prio(cfg_prio), .ack_irq(ack[0]), .ack_fiq(ack[1]),
    .stat_wr(stat_wr), .rdata(rdata)
  );

  irq_bank_status #(.N_LINES(N_LINES)) u_status (
    .clk(clk), .rst(rst), .req(req_i), .cfg_lvl(cfg_lvl),
    .clr(clr[0] | clr[1]), .stat_wr(stat_wr),
    .wdata(wdata[N_LINES-1:0]), .status(status)
  );

  assign elig[0] = status & ~mask & ~cfg_fiq;
  assign elig[1] = status & ~mask &  cfg_fiq;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    if (k == 0 || IS_PRIMARY) begin : g_arb
      irq_bank_arb #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .clk(clk), .rst(rst), .elig(elig[k]), .prio(cfg_prio),
        .ack(ack[k]), .hold(hold[k]), .win_idx(win[k]), .clr(clr[k])
      );
    end else begin : g_none
      assign hold[k] = 1'b0;
      assign win[k]  = '0;
      assign clr[k]  = '0;
    end
  end

  assign irq_o = hold[0] & ~gmask;
  assign fiq_o = hold[1] & ~gmask;
endmodule

// File: tb/irq_bank_bench.sv
module irq_bank_bench;
  import irq_bank_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk; // 125 MHz

  logic [31:0] p_req = '0, s_req = '0, p_req_eff;
  logic        p_wr = 0, p_rd = 0, s_wr = 0, s_rd = 0;
  logic [7:0]  p_addr = '0, s_addr = '0;
  logic [31:0] p_wdata = '0, s_wdata = '0, p_rdata, s_rdata;
  logic        p_irq, p_fiq, s_irq, s_fiq;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  assign p_req_eff = p_req | {31'b0, s_irq}; // secondary chains into primary line 0

  irq_bank #(.IS_PRIMARY(1'b1)) u_irq_bank (
    .clk(clk), .rst(rst), .req_i(p_req_eff), .wr_en(p_wr), .rd_en(p_rd),
    .addr(p_addr), .wdata(p_wdata), .rdata(p_rdata), .irq_o(p_irq), .fiq_o(p_fiq));

  irq_bank #(.IS_PRIMARY(1'b0)) u_irq_bank_sec (
    .clk(clk), .rst(rst), .req_i(s_req), .wr_en(s_wr), .rd_en(s_rd),
    .addr(s_addr), .wdata(s_wdata), .rdata(s_rdata), .irq_o(s_irq), .fiq_o(s_fiq));

  // {request pattern, expect valid, expect winner}; line n has priority n%4, level
  localparam logic [37:0] VEC [8] = '{
    {32'h0000_0001, 1'b1, 5'd0},
    {32'h0000_0006, 1'b1, 5'd1},
    {32'h0000_0030, 1'b1, 5'd4},
    {32'h8000_0000, 1'b1, 5'd31},
    {32'h8000_0100, 1'b1, 5'd8},
    {32'h0000_0022, 1'b1, 5'd1},
    {32'h4000_0080, 1'b1, 5'd30},
    {32'h0000_0000, 1'b0, 5'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sec, input logic [7:0] a, input logic [31:0] d);
    if (sec) begin s_wr = 1; s_addr = a; s_wdata = d; end
    else     begin p_wr = 1; p_addr = a; p_wdata = d; end
    @(negedge clk);
    s_wr = 0; p_wr = 0;
  endtask

  task automatic rd(input bit sec, input logic [7:0] a, output logic [31:0] d);
    if (sec) begin s_rd = 1; s_addr = a; end
    else     begin p_rd = 1; p_addr = a; end
    @(negedge clk);
    d = sec ? s_rdata : p_rdata;
    s_rd = 0; p_rd = 0;
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);

    // reset state
    check("R13 irq after reset", {31'b0, p_irq}, 32'h0);
    check("R13 fiq after reset", {31'b0, p_fiq}, 32'h0);
    rd(0, 8'h04, rv); check("R2 mask reset", rv, 32'hFFFF_FFFF);
    rd(0, 8'h14, rv); check("R3 gmask reset", rv, 32'h1);
    rd(0, 8'h00, rv); check("R13 status reset", rv, 32'h0);
    rd(0, 8'h08, rv); check("R13 source reset", rv, 32'h0);
    rd(0, 8'h8C, rv); check("R1 cfg reset", rv, 32'h0);

    // setup primary: all level, priority n%4
    wr(0, 8'h14, 32'h0);
    wr(0, 8'h04, 32'h0);
    for (int n = 0; n < 32; n++) wr(0, 8'(8'h80 + 4 * n), 32'((n % 4) << 2) | 32'h2);
    rd(0, 8'h9C, rv); check("R1 cfg readback line7", rv, 32'hE);

    // table walk: arbitration order
    for (int i = 0; i < 8; i++) begin
      p_req = VEC[i][37:6];
      step(2);
      check("R7 irq raised", {31'b0, p_irq}, {31'b0, VEC[i][5]});
      if (VEC[i][5]) begin
        rd(0, 8'h08, rv);
        check("R7 winner", rv, 32'h8000_0000 | 32'(VEC[i][4:0]));
      end
      p_req = '0;
      wr(0, 8'h10, 32'h1);
      check("R10 low after ack", {31'b0, p_irq}, 32'h0);
      step(1);
    end

    // mask and global mask
    wr(0, 8'h04, 32'h10);
    p_req = 32'h10;
    step(3);
    check("R2 masked line silent", {31'b0, p_irq}, 32'h0);
    rd(0, 8'h00, rv); check("R6 level status while masked", rv, 32'h10);
    wr(0, 8'h04, 32'h0);
    step(1);
    check("R2 unmasked line raises", {31'b0, p_irq}, 32'h1);
    wr(0, 8'h14, 32'h1);
    check("R3 gmask blocks", {31'b0, p_irq}, 32'h0);
    wr(0, 8'h14, 32'h0);
    check("R3 gmask release", {31'b0, p_irq}, 32'h1);
    p_req = '0;
    step(2);
    rd(0, 8'h00, rv); check("R6 level status follows low", rv, 32'h0);
    check("R8 held after level drop", {31'b0, p_irq}, 32'h1);
    wr(0, 8'h10, 32'h1);
    check("R10 ack drops", {31'b0, p_irq}, 32'h0);
    step(1);

    // fast routing and independent acks
    wr(0, 8'h8C, 32'h3);
    p_req = 32'h48;
    step(2);
    check("R4 fiq raised in primary", {31'b0, p_fiq}, 32'h1);
    check("R7 irq raised alongside", {31'b0, p_irq}, 32'h1);
    rd(0, 8'h0C, rv); check("R8 fiq source", rv, 32'h8000_0003);
    rd(0, 8'h08, rv); check("R7 fiq line excluded from irq", rv, 32'h8000_0006);
    wr(0, 8'h10, 32'h1);
    check("R10 irq low after ack", {31'b0, p_irq}, 32'h0);
    check("R9 fiq kept by irq ack", {31'b0, p_fiq}, 32'h1);
    step(1);
    check("R10 rearbitration", {31'b0, p_irq}, 32'h1);
    p_req = '0;
    wr(0, 8'h10, 32'h3);
    check("R9 both acked irq", {31'b0, p_irq}, 32'h0);
    check("R9 both acked fiq", {31'b0, p_fiq}, 32'h0);
    step(2);
    wr(0, 8'h8C, 32'hE);

    // edge latching and second pending line
    wr(0, 8'hA4, 32'h4);
    wr(0, 8'hA8, 32'h4);
    p_req = 32'h600; step(1); p_req = '0; step(1);
    check("R5 edge latched", {31'b0, p_irq}, 32'h1);
    step(3);
    check("R5 edge still held", {31'b0, p_irq}, 32'h1);
    rd(0, 8'h08, rv); check("R7 tie to lower index", rv, 32'h8000_0009);
    rd(0, 8'h00, rv); check("R5 edge status", rv, 32'h600);
    wr(0, 8'h10, 32'h1);
    check("R10 gap cycle", {31'b0, p_irq}, 32'h0);
    step(1);
    check("R10 next line presented", {31'b0, p_irq}, 32'h1);
    rd(0, 8'h08, rv); check("R10 next source", rv, 32'h8000_000A);
    rd(0, 8'h00, rv); check("R10 acked bit cleared", rv, 32'h400);
    wr(0, 8'h10, 32'h1);
    step(2);
    check("R10 idle after last ack", {31'b0, p_irq}, 32'h0);

    // frozen winner
    wr(0, 8'hB0, 32'h14);
    wr(0, 8'hB4, 32'h0);
    p_req = 32'h1000; step(1); p_req = '0; step(1);
    p_req = 32'h2000; step(1); p_req = '0; step(2);
    rd(0, 8'h08, rv); check("R8 winner frozen", rv, 32'h8000_000C);
    wr(0, 8'h10, 32'h1);
    step(1);
    rd(0, 8'h08, rv); check("R8 better line after ack", rv, 32'h8000_000D);
    wr(0, 8'h10, 32'h1);
    step(2);

    // status writes
    wr(0, 8'h04, 32'hFFFF_FFFF);
    p_req = 32'h600; step(1); p_req = '0; step(1);
    rd(0, 8'h00, rv); check("R11 latched before write", rv, 32'h600);
    wr(0, 8'h00, ~32'h200);
    rd(0, 8'h00, rv); check("R11 AND write", rv, 32'h400);
    wr(0, 8'h00, 32'h0);
    rd(0, 8'h00, rv); check("R11 zero write clears", rv, 32'h0);
    wr(0, 8'h04, 32'h0);
    step(2);
    check("R11 nothing pending", {31'b0, p_irq}, 32'h0);

    // secondary bank and cascade
    wr(1, 8'h14, 32'h0);
    wr(1, 8'h04, 32'h0);
    wr(1, 8'h94, 32'h7);
    rd(1, 8'h94, rv); check("R4 fiq bit forced in secondary", rv, 32'h6);
    wr(1, 8'h94, 32'h1);
    rd(1, 8'h94, rv); check("R1 secondary cfg edge", rv, 32'h0);
    s_req = 32'h20; step(1); s_req = '0; step(1);
    check("R4 secondary routes to irq", {31'b0, s_irq}, 32'h1);
    check("R4 secondary fiq quiet", {31'b0, s_fiq}, 32'h0);
    step(2);
    check("R12 primary sees cascade", {31'b0, p_irq}, 32'h1);
    rd(0, 8'h08, rv); check("R12 primary source", rv, 32'h8000_0000);
    wr(1, 8'h10, 32'h1);
    check("R12 secondary acked", {31'b0, s_irq}, 32'h0);
    check("R12 primary still held", {31'b0, p_irq}, 32'h1);
    wr(0, 8'h10, 32'h1);
    check("R12 primary acked", {31'b0, p_irq}, 32'h0);
    step(3);
    check("R12 primary stays low", {31'b0, p_irq}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule